// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block is the master end of an 8-bit processor's external memory bus. It runs from the crystal-rate clock and divides it by four to produce the bus strobe E. Each E period is one bus cycle. A cycle starts when E falls. An address strobe, AS, occupies the first quarter of the cycle. R/W and the upper address byte change only when AS rises. A single 8-bit pin group carries two things in turn. During AS it carries the low address byte, which an external transparent latch captures. During the E-high half it carries data.

A requester presents one read or write at a time with a 16-bit address and a write byte. The request is taken only at the clock edge where E falls and the next cycle begins. For a read, the pins are released as soon as AS drops, and the returned byte is captured at the falling edge of E. For a write, the block drives the byte for the whole E-high half. One clock after that E fall, a single-clock completion pulse is issued, and for reads it carries the byte. When no request is pending, the bus keeps strobing with read polarity and repeats the last address.

The pad is split into an output value, an output enable and an input value. A pad ring or the bench builds the tri-state pin from these three signals.

Top module: `mux_bus_seq`

## Requirements
- R1: E is low for two clocks and then high for two clocks, repeating, so its frequency is one quarter of the clock.
- R2: AS is high for exactly the one clock that directly follows each falling edge of E and is never high while E is high.
- R3: R/W and the upper address output change only on the edge where AS rises. R/W is 0 for a write cycle and 1 for a read or idle cycle, and the upper output is address bits [15:8].
- R4: While AS is high, the shared pins are enabled and carry address bits [7:0].
- R5: In a read cycle, the pin enable is low from the fall of AS to the end of the cycle. The output byte takes the value on the pin inputs in the last clock of E high, just before E falls.
- R6: In a write cycle, the pin enable is low for the one clock after AS falls. It is then high, carrying the write byte, for both E-high clocks.
- R7: The completion pulse is high for exactly one clock, the first clock after the E fall that ends an accepted cycle, for reads and writes alike. The read byte output holds its value except at a read completion.
- R8: A pending request is accepted only in the clock whose next edge makes E fall. The take output is high in exactly that clock, and a request held at any other time has no effect until then.
- R9: A cycle with no accepted request still pulses E and AS and keeps R/W at 1. It drives the previous address on both address outputs and produces no completion or read byte update.
- R10: While reset is sampled high, the next edge forces E=0, AS=0, R/W=1, pin enable 0, completion 0, upper address 0 and read byte 0, and abandons any cycle. E rises on the first edge with reset low, and the first acceptance point is the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_take | output | 1 | Request accepted in this clock |
| xfer_done | output | 1 | One-clock completion pulse |
| xfer_rdata | output | 8 | Byte captured by the last read |
| bus_e | output | 1 | Bus strobe E |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_hi | output | 8 | Upper address byte |
| bus_ad_o | output | 8 | Shared pin output value |
| bus_ad_oe | output | 1 | Shared pin output enable |
| bus_ad_i | input | 8 | Shared pin input value |

## Verification
The bench builds the block with its default 16-bit address and 8-bit data. With those widths, the extreme addresses 0x0000 and 0xFFFF and an all-ones write byte reach every pin of both address outputs and the data path. The bench models an external latch that catches the low byte while AS is high. It returns an address-dependent byte only while E is high with read polarity, so a capture one clock early or late, or a wrongly latched address, gives a wrong byte. It also covers back-to-back cycles, a long idle stretch, a request held across non-boundary clocks and a reset in the middle of a write.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    // Quarter-cycle phases of one bus cycle; phase 0 follows the fall of E.
    typedef enum logic [1:0] {
        PH_ASTB  = 2'd0,   // E low, address strobe high
        PH_SETUP = 2'd1,   // E low, strobe low, pins turn around
        PH_EHI_A = 2'd2,   // E high, first clock
        PH_EHI_B = 2'd3    // E high, last clock before E falls
    } phase_e;

    function automatic phase_e next_phase(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

    function automatic logic phase_is_ehi(input phase_e p);
        return (p == PH_EHI_A) || (p == PH_EHI_B);
    endfunction

endpackage

// File: rtl/mbs_phase.sv
module mbs_phase
    import mbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph_o,
    output phase_e ph_nxt_o,
    output logic   boundary_o
);

    typedef struct packed {
        phase_e ph;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = next_phase(st_q.ph);
        if (rst) begin
            // Park in the E-low, strobe-low phase.
            st_d.ph = PH_SETUP;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ph_o       = st_q.ph;
    assign ph_nxt_o   = st_d.ph;
    assign boundary_o = (st_q.ph == PH_EHI_B);

endmodule

// File: rtl/mbs_req.sv
module mbs_req #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_take_o,
    output logic              cur_act_o,
    output logic              cur_wr_o,
    output logic              nxt_act_o,
    output logic              nxt_wr_o,
    output logic [ADDR_W-1:0] nxt_addr_o,
    output logic [DATA_W-1:0] nxt_wdata_o
);

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_st_t;

    req_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d = st_q;
        take = boundary_i && req_valid_i && !rst;
        if (boundary_i) begin
            if (req_valid_i) begin
                st_d.act   = 1'b1;
                st_d.wr    = req_write_i;
                st_d.addr  = req_addr_i;
                st_d.wdata = req_wdata_i;
            end else begin
                // Idle cycle: keep address, read polarity.
                st_d.act = 1'b0;
                st_d.wr  = 1'b0;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req_take_o  = take;
    assign cur_act_o   = st_q.act;
    assign cur_wr_o    = st_q.wr;
    assign nxt_act_o   = st_d.act;
    assign nxt_wr_o    = st_d.wr;
    assign nxt_addr_o  = st_d.addr;
    assign nxt_wdata_o = st_d.wdata;

endmodule

// File: rtl/mbs_port.sv
module mbs_port
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  phase_e                   ph_i,
    input  phase_e                   ph_nxt_i,
    input  logic                     cur_act_i,
    input  logic                     cur_wr_i,
    input  logic                     nxt_act_i,
    input  logic                     nxt_wr_i,
    input  logic [ADDR_W-1:0]        nxt_addr_i,
    input  logic [DATA_W-1:0]        nxt_wdata_i,
    input  logic [DATA_W-1:0]        pin_i,
    output logic                     e_o,
    output logic                     as_o,
    output logic                     rw_o,
    output logic [ADDR_W-DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0]        pin_o,
    output logic                     pin_oe_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic                     done_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic              e;
        logic              as;
        logic              rw;
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] pin;
        logic              oe;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     wr_cyc;
    logic     last_q;

    always_comb begin
        st_d   = st_q;
        wr_cyc = nxt_act_i && nxt_wr_i;
        last_q = (ph_i == PH_EHI_B);

        // Strobes and address, registered from the next phase.
        st_d.e  = phase_is_ehi(ph_nxt_i);
        st_d.as = (ph_nxt_i == PH_ASTB);
        st_d.rw = !wr_cyc;
        st_d.hi = nxt_addr_i[ADDR_W-1:DATA_W];

        // Shared pins: low address under the strobe, write byte while E high.
        st_d.oe = st_d.as || (st_d.e && wr_cyc);
        if (st_d.as) begin
            st_d.pin = nxt_addr_i[DATA_W-1:0];
        end else if (st_d.e && wr_cyc) begin
            st_d.pin = nxt_wdata_i;
        end else begin
            st_d.pin = '0;
        end

        // Capture and completion at the edge where E falls.
        st_d.done = last_q && cur_act_i;
        if (last_q && cur_act_i && !cur_wr_i) begin
            st_d.rdata = pin_i;
        end

        if (rst) begin
            st_d    = '0;
            st_d.rw = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign e_o      = st_q.e;
    assign as_o     = st_q.as;
    assign rw_o     = st_q.rw;
    assign hi_o     = st_q.hi;
    assign pin_o    = st_q.pin;
    assign pin_oe_o = st_q.oe;
    assign rdata_o  = st_q.rdata;
    assign done_o   = st_q.done;

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_take,
    output logic                     xfer_done,
    output logic [DATA_W-1:0]        xfer_rdata,
    output logic                     bus_e,
    output logic                     bus_as,
    output logic                     bus_rw,
    output logic [ADDR_W-DATA_W-1:0] bus_hi,
    output logic [DATA_W-1:0]        bus_ad_o,
    output logic                     bus_ad_oe,
    input  logic [DATA_W-1:0]        bus_ad_i
);

    phase_e              ph, ph_nxt;
    logic                boundary;
    logic                cur_act, cur_wr, nxt_act, nxt_wr;
    logic [ADDR_W-1:0]   nxt_addr;
    logic [DATA_W-1:0]   nxt_wdata;

    mbs_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .ph_o       (ph),
        .ph_nxt_o   (ph_nxt),
        .boundary_o (boundary)
    );

    mbs_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk         (clk),
        .rst         (rst),
        .boundary_i  (boundary),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .req_take_o  (req_take),
        .cur_act_o   (cur_act),
        .cur_wr_o    (cur_wr),
        .nxt_act_o   (nxt_act),
        .nxt_wr_o    (nxt_wr),
        .nxt_addr_o  (nxt_addr),
        .nxt_wdata_o (nxt_wdata)
    );

    mbs_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk         (clk),
        .rst         (rst),
        .ph_i        (ph),
        .ph_nxt_i    (ph_nxt),
        .cur_act_i   (cur_act),
        .cur_wr_i    (cur_wr),
        .nxt_act_i   (nxt_act),
        .nxt_wr_i    (nxt_wr),
        .nxt_addr_i  (nxt_addr),
        .nxt_wdata_i (nxt_wdata),
        .pin_i       (bus_ad_i),
        .e_o         (bus_e),
        .as_o        (bus_as),
        .rw_o        (bus_rw),
        .hi_o        (bus_hi),
        .pin_o       (bus_ad_o),
        .pin_oe_o    (bus_ad_oe),
        .rdata_o     (xfer_rdata),
        .done_o      (xfer_done)
    );

endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_take,
    input logic                     xfer_done,
    input logic                     bus_e,
    input logic                     bus_as,
    input logic                     bus_rw,
    input logic [ADDR_W-DATA_W-1:0] bus_hi,
    input logic                     bus_ad_oe
);

    AST_E_HIGH_TWO: assert property (@(posedge clk) disable iff (rst) $rose(bus_e) |=> bus_e);                         // R1
    AST_AS_E_LOW: assert property (@(posedge clk) disable iff (rst) bus_as |-> !bus_e);                                // R2
    AST_AS_ONE_CLK: assert property (@(posedge clk) disable iff (rst) bus_as |=> !bus_as);                             // R2
    AST_RW_AT_AS: assert property (@(posedge clk) disable iff (rst) !$stable(bus_rw) |-> $rose(bus_as));               // R3
    AST_HI_AT_AS: assert property (@(posedge clk) disable iff (rst) !$stable(bus_hi) |-> $rose(bus_as));               // R3
    AST_AS_DRIVES: assert property (@(posedge clk) disable iff (rst) bus_as |-> bus_ad_oe);                            // R4
    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (rst) (bus_rw && !bus_as) |-> !bus_ad_oe);             // R5
    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (rst) (bus_ad_oe && !bus_as) |-> (!bus_rw && bus_e)); // R6
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst) xfer_done |=> !xfer_done);                         // R7
    AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) xfer_done |-> $fell(bus_e));                // R7
    AST_TAKE_BOUNDARY: assert property (@(posedge clk) disable iff (rst) req_take |=> bus_as);                         // R8

endmodule

bind mux_bus_seq mbs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_take  (req_take),
    .xfer_done (xfer_done),
    .bus_e     (bus_e),
    .bus_as    (bus_as),
    .bus_rw    (bus_rw),
    .bus_hi    (bus_hi),
    .bus_ad_oe (bus_ad_oe)
);

// File: tb/tb_mux_bus_seq.sv
`timescale 1ns/1ps
module tb_mux_bus_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_take, xfer_done, bus_e, bus_as, bus_rw, bus_ad_oe;
    logic [7:0]  xfer_rdata, bus_hi, bus_ad_o, bus_ad_i;
    logic [7:0]  ext_lo = '0;

    int n_vec = 0;
    int n_err = 0;
    int cyc   = 0;

    // Behavioural model state
    int          m_ph   = 1;
    logic        m_act  = 1'b0;
    logic        m_wr   = 1'b0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd   = '0;
    logic        m_done = 1'b0;
    logic [7:0]  m_rd   = '0;
    logic        m_rst  = 1'b1;

    always #2.5 clk = ~clk;

    mux_bus_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_take(req_take),
        .xfer_done(xfer_done), .xfer_rdata(xfer_rdata), .bus_e(bus_e),
        .bus_as(bus_as), .bus_rw(bus_rw), .bus_hi(bus_hi), .bus_ad_o(bus_ad_o),
        .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[15:8] ^ (a[7:0] * 8'd3) ^ 8'h5A;
    endfunction

    // External low-address latch and memory device.
    always @(negedge clk) if (bus_as && bus_ad_oe) ext_lo = bus_ad_o;
    assign bus_ad_i = (bus_e && bus_rw) ? mem_f({bus_hi, ext_lo}) : 8'hEE;

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s at cycle %0d: got %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    // Reference model advance
    always @(posedge clk) begin
        cyc++;
        m_rst = rst;
        if (rst) begin
            m_ph = 1; m_act = 0; m_wr = 0; m_addr = '0; m_wd = '0; m_done = 0; m_rd = '0;
        end else begin
            if (m_ph == 3) begin
                m_done = m_act;
                if (m_act && !m_wr) m_rd = mem_f(m_addr);
                if (req_valid) begin
                    m_act = 1; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
                end else begin
                    m_act = 0; m_wr = 0;
                end
            end else begin
                m_done = 0;
            end
            m_ph = (m_ph + 1) % 4;
        end
        if (cyc > 5000) begin
            n_err++;
            $display("FAIL watchdog (all R): cycles %0d expected at most 5000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0) begin
            logic e_x, as_x, rw_x, oe_x, tk_x;
            string t_rw, t_oe;
            e_x  = (m_ph >= 2);
            as_x = (m_ph == 0);
            rw_x = !(m_act && m_wr);
            oe_x = as_x || (e_x && m_act && m_wr);
            tk_x = (m_ph == 3) && req_valid && !rst;
            t_rw = m_rst ? "R10" : (m_act ? "R3" : "R9");
            t_oe = m_rst ? "R10" : (as_x ? "R4" : (m_act && m_wr) ? "R6" : "R5");
            chk(m_rst ? "R10" : "R1", "bus_e", 16'(bus_e), 16'(e_x));
            chk(m_rst ? "R10" : "R2", "bus_as", 16'(bus_as), 16'(as_x));
            chk(t_rw, "bus_rw", 16'(bus_rw), 16'(rw_x));
            chk(t_rw, "bus_hi", 16'(bus_hi), 16'(m_addr[15:8]));
            chk(t_oe, "bus_ad_oe", 16'(bus_ad_oe), 16'(oe_x));
            if (oe_x && as_x) chk(m_act ? "R4" : "R9", "low address", 16'(bus_ad_o), 16'(m_addr[7:0]));
            if (oe_x && !as_x) chk("R6", "write byte", 16'(bus_ad_o), 16'(m_wd));
            chk(m_rst ? "R10" : "R7", "xfer_done", 16'(xfer_done), 16'(m_done));
            chk(m_rst ? "R10" : "R5", "xfer_rdata", 16'(xfer_rdata), 16'(m_rd));
            chk("R8", "req_take", 16'(req_take), 16'(tk_x));
        end
    end

    task automatic do_req(input logic w, input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_take);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        do_req(1'b0, 16'h1234, 8'h00);   // R5 read
        do_req(1'b1, 16'hABCD, 8'h5E);   // R6 write
        do_req(1'b0, 16'h0000, 8'h00);   // back-to-back
        do_req(1'b1, 16'hFFFF, 8'hFF);
        repeat (12) @(posedge clk);      // R9 idle cycles
        #1;
        do_req(1'b0, 16'h8004, 8'h00);   // R8 held request
        repeat (5) @(posedge clk);
        do_req(1'b1, 16'h8000, 8'hC3);   // R10 reset mid-write
        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        do_req(1'b0, 16'hC0DE, 8'h00);
        repeat (8) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule